// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor and a main-memory port. It is set-associative, and each set holds a number of ways. It follows a write-back, write-allocate policy. Replacement uses an age value per block, and the oldest block is evicted. On the processor side there is one word-wide request port. A hit returns data in the same cycle it is presented. A miss raises a stall that holds until the block has been brought in.

On the memory side the block moves whole blocks, one word per beat. Each beat is completed by an acknowledge. The memory marks the last beat with a finished strobe. When the victim of a miss is dirty, its contents are written back to its old address before the refill is read. After the refill is installed, the held request completes as an ordinary hit.

Both sides interact with a few simple rules. The processor must hold its request, address and write data steady while the stall is high. Byte-offset bits of the address are ignored, because every access is one full word.

Top module: `wbc_cache`

## Requirements
- R1: The byte address is split, starting from the low end, into byte bits [1:0] (ignored), word-in-block bits [4:2], set bits [8:5] and tag bits [31:9] (default geometry). Two addresses that differ only in bits [1:0] reach the same word.
- R2: A request hits only when a valid way of the selected set holds a matching tag. On a hit, `cpu_stall` is low in the same cycle and `cpu_rdata` carries the stored word.
- R3: A write hit changes only the cached word and marks that block dirty. It causes no memory traffic.
- R4: On a miss, `cpu_stall` stays high until the refill is complete. The refill reads the block's eight words as beats with word bits 0 through 7 in order, then the request completes as a hit.
- R5: A write miss first refills the block, then applies the write and marks the block dirty.
- R6: A dirty victim is written back to its own old block address, as eight beats with word bits 0 through 7, before the refill starts. A clean victim produces no write traffic.
- R7: Each way holds a 2-bit age. Accessing a way sets its age to 0, and every way in the set that was younger than it ages by one. Among valid ways, the victim is the one with age 3.
- R8: While a set still has an invalid way, a miss fills the lowest-numbered invalid way and evicts nothing.
- R9: A beat completes on a cycle with `mem_ack` high, and the transfer ends on the cycle `mem_fin` accompanies the final `mem_ack`. Between beats the address and write data are held, and `mem_rd` and `mem_wr` are never high together.
- R10: After reset every way is invalid, no memory request is driven, and `cpu_stall` is low while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write word |
| cpu_rdata | output | 32 | Read word, valid when the request is not stalled |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_rd | output | 1 | Refill read in progress |
| mem_wr | output | 1 | Victim writeback in progress |
| mem_addr | output | 32 | Byte address of the current beat |
| mem_wdata | output | 32 | Writeback word of the current beat |
| mem_rdata | input | 32 | Refill word of the current beat |
| mem_ack | input | 1 | Current beat completes this cycle |
| mem_fin | input | 1 | Final beat of the block transfer |

## Verification
Two things can happen in the same cycle. On the final refill beat, the last word is captured while `mem_fin` ends the transfer and installs the tag. The memory model raises the finished strobe on the same cycle as the last acknowledge, after randomly placed gaps between beats, so the capture and the install always coincide. Correctness is judged by later reads, which must return the word the bench holds in its shadow memory. A second collision is a write hit that refreshes the LRU ages of the whole set in the same cycle that it marks the block dirty. A reference model predicts which block a later eviction writes back, and the bench compares that prediction with the writeback address seen at the memory port.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_EVICT  = 2'd1,
    CS_REFILL = 2'd2
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
// Tag, valid, dirty and age state for every set; hit detect and victim pick.
module wbc_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int TAG_W = 23
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(SETS)-1:0]     lk_set,
  input  logic [TAG_W-1:0]            lk_tag,
  input  logic                        touch_en,
  input  logic [$clog2(WAYS)-1:0]     touch_way,
  input  logic                        touch_dirty,
  input  logic                        fill_en,
  input  logic [$clog2(WAYS)-1:0]     fill_way,
  output logic                        hit,
  output logic [$clog2(WAYS)-1:0]     hit_way,
  output logic [$clog2(WAYS)-1:0]     vic_way,
  output logic                        vic_dirty,
  output logic [TAG_W-1:0]            vic_tag
);
  localparam int WAY_BITS = $clog2(WAYS);
  localparam logic [WAY_BITS-1:0] OLDEST = WAY_BITS'(WAYS - 1);

  logic [TAG_W-1:0]    tag_q   [SETS][WAYS];
  logic [WAYS-1:0]     valid_q [SETS];
  logic [WAYS-1:0]     dirty_q [SETS];
  logic [WAY_BITS-1:0] age_q   [SETS][WAYS];

  logic [WAYS-1:0]     row_valid, row_dirty, valid_d, dirty_d, way_match;
  logic [WAY_BITS-1:0] row_age [WAYS];
  logic [WAY_BITS-1:0] age_d   [WAYS];
  logic                row_we;

  assign row_valid = valid_q[lk_set];
  assign row_dirty = dirty_q[lk_set];

  always_comb begin
    for (int w = 0; w < WAYS; w++) row_age[w] = age_q[lk_set][w];
  end

  // Per-way tag comparators
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign way_match[g] = row_valid[g] && (tag_q[lk_set][g] == lk_tag);
  end

  always_comb begin
    hit     = |way_match;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_match[w]) hit_way = WAY_BITS'(w);
  end

  // Victim: lowest invalid way first, otherwise the way whose age is maximal
  always_comb begin
    logic found;
    found   = 1'b0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !row_valid[w]) begin
        vic_way = WAY_BITS'(w);
        found   = 1'b1;
      end
    end
    if (!found) begin
      for (int w = 0; w < WAYS; w++)
        if (row_age[w] == OLDEST) vic_way = WAY_BITS'(w);
    end
  end

  assign vic_dirty = row_valid[vic_way] && row_dirty[vic_way];
  assign vic_tag   = tag_q[lk_set][vic_way];

  // Next state of the addressed row
  always_comb begin
    valid_d = row_valid;
    dirty_d = row_dirty;
    for (int w = 0; w < WAYS; w++) age_d[w] = row_age[w];
    if (fill_en) begin
      valid_d[fill_way] = 1'b1;
      dirty_d[fill_way] = 1'b0;
    end
    if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_BITS'(w) == touch_way)
          age_d[w] = '0;
        else if (row_age[w] < row_age[touch_way])
          age_d[w] = row_age[w] + 1'b1;
      end
      if (touch_dirty) dirty_d[touch_way] = 1'b1;
    end
  end

  assign row_we = fill_en || touch_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_BITS'(w);
      end
    end else if (row_we) begin
      valid_q[lk_set] <= valid_d;
      dirty_q[lk_set] <= dirty_d;
      for (int w = 0; w < WAYS; w++) age_q[lk_set][w] <= age_d[w];
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[lk_set][fill_way] <= lk_tag;
  end
endmodule

// File: rtl/wbc_data_store.sv
// Block data array, one write port and one asynchronous read port.
module wbc_data_store #(
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32
) (
  input  logic                                  clk,
  input  logic                                  wr_en,
  input  logic [$clog2(SETS*WAYS*WORDS)-1:0]    wr_idx,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic [$clog2(SETS*WAYS*WORDS)-1:0]    rd_idx,
  output logic [DATA_W-1:0]                     rd_data
);
  localparam int DEPTH = SETS * WAYS * WORDS;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/wbc_miss_ctrl.sv
// Miss sequencer: optional writeback of the victim, then refill, beat counting.
module wbc_miss_ctrl #(
  parameter int WORD_BITS = 3,
  parameter int WAY_BITS  = 2,
  parameter int TAG_W     = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   hit,
  input  logic                   vic_dirty,
  input  logic [WAY_BITS-1:0]    vic_way,
  input  logic [TAG_W-1:0]       vic_tag,
  input  logic                   mem_ack,
  input  logic                   mem_fin,
  output wbc_pkg::wbc_state_e    state,
  output logic [WORD_BITS-1:0]   beat,
  output logic [WAY_BITS-1:0]    held_way,
  output logic [TAG_W-1:0]       held_tag,
  output logic                   refill_we,
  output logic                   refill_done
);
  import wbc_pkg::*;

  wbc_state_e           state_q, state_d;
  logic [WORD_BITS-1:0] beat_q, beat_d;
  logic                 capture_en, beat_en;

  assign capture_en = (state_q == CS_IDLE) && req && !hit;
  assign beat_en    = (state_q != CS_IDLE) && mem_ack;

  always_comb begin
    state_d = state_q;
    case (state_q)
      CS_IDLE:   if (capture_en) state_d = vic_dirty ? CS_EVICT : CS_REFILL;
      CS_EVICT:  if (mem_fin)    state_d = CS_REFILL;
      CS_REFILL: if (mem_fin)    state_d = CS_IDLE;
      default:                   state_d = CS_IDLE;
    endcase
  end

  always_comb begin
    beat_d = beat_q;
    if (beat_en) beat_d = mem_fin ? '0 : beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat_en) beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (capture_en) begin
      held_way <= vic_way;
      held_tag <= vic_tag;
    end
  end

  assign state       = state_q;
  assign beat        = beat_q;
  assign refill_we   = (state_q == CS_REFILL) && mem_ack;
  assign refill_done = (state_q == CS_REFILL) && mem_fin;
endmodule

// File: rtl/wbc_cache.sv
// Set-associative write-back, write-allocate data cache with age-based LRU.
module wbc_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int WORDS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_fin
);
  import wbc_pkg::*;

  localparam int BYTE_OFF  = $clog2(DATA_W / 8);
  localparam int WORD_BITS = $clog2(WORDS);
  localparam int SET_BITS  = $clog2(SETS);
  localparam int WAY_BITS  = $clog2(WAYS);
  localparam int TAG_LSB   = BYTE_OFF + WORD_BITS + SET_BITS;
  localparam int TAG_W     = ADDR_W - TAG_LSB;
  localparam int IDX_W     = SET_BITS + WAY_BITS + WORD_BITS;

  logic [WORD_BITS-1:0] a_word;
  logic [SET_BITS-1:0]  a_set;
  logic [TAG_W-1:0]     a_tag;
  logic                 unused_byte_bits;

  assign a_word = cpu_addr[BYTE_OFF +: WORD_BITS];
  assign a_set  = cpu_addr[BYTE_OFF + WORD_BITS +: SET_BITS];
  assign a_tag  = cpu_addr[ADDR_W-1:TAG_LSB];
  assign unused_byte_bits = ^cpu_addr[BYTE_OFF-1:0];

  wbc_state_e           st;
  logic [WORD_BITS-1:0] beat;
  logic [WAY_BITS-1:0]  hit_way, vic_way, held_way;
  logic [TAG_W-1:0]     vic_tag, held_tag;
  logic                 hit, vic_dirty, refill_we, refill_done;
  logic                 idle, touch_en, cpu_wr_en;
  logic                 dat_we;
  logic [IDX_W-1:0]     wr_idx, rd_idx;
  logic [DATA_W-1:0]    wr_data, rd_data;

  assign idle      = (st == CS_IDLE);
  assign touch_en  = idle && cpu_req && hit;
  assign cpu_wr_en = touch_en && cpu_we;

  wbc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_set     (a_set),
    .lk_tag     (a_tag),
    .touch_en   (touch_en),
    .touch_way  (hit_way),
    .touch_dirty(cpu_we),
    .fill_en    (refill_done),
    .fill_way   (held_way),
    .hit        (hit),
    .hit_way    (hit_way),
    .vic_way    (vic_way),
    .vic_dirty  (vic_dirty),
    .vic_tag    (vic_tag)
  );

  wbc_miss_ctrl #(.WORD_BITS(WORD_BITS), .WAY_BITS(WAY_BITS), .TAG_W(TAG_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (cpu_req),
    .hit        (hit),
    .vic_dirty  (vic_dirty),
    .vic_way    (vic_way),
    .vic_tag    (vic_tag),
    .mem_ack    (mem_ack),
    .mem_fin    (mem_fin),
    .state      (st),
    .beat       (beat),
    .held_way   (held_way),
    .held_tag   (held_tag),
    .refill_we  (refill_we),
    .refill_done(refill_done)
  );

  assign dat_we  = cpu_wr_en || refill_we;
  assign wr_idx  = refill_we ? {a_set, held_way, beat} : {a_set, hit_way, a_word};
  assign wr_data = refill_we ? mem_rdata : cpu_wdata;
  assign rd_idx  = (st == CS_EVICT) ? {a_set, held_way, beat} : {a_set, hit_way, a_word};

  wbc_data_store #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .wr_en  (dat_we),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  assign cpu_rdata = rd_data;
  assign mem_wdata = rd_data;
  assign cpu_stall = !idle || (cpu_req && !hit);
  assign mem_rd    = (st == CS_REFILL);
  assign mem_wr    = (st == CS_EVICT);
  assign mem_addr  = {((st == CS_EVICT) ? held_tag : a_tag), a_set, beat, {BYTE_OFF{1'b0}}};
endmodule

// File: rtl/wbc_cache_chk.sv
// Protocol checker bound to the cache top.
module wbc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SETS   = 16,
  parameter int WORDS  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_stall,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              mem_fin
);
  localparam int BYTE_OFF  = $clog2(DATA_W / 8);
  localparam int WORD_BITS = $clog2(WORDS);

  p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_mem_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> cpu_stall);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

  p_wb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  p_first_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |-> (mem_addr[BYTE_OFF +: WORD_BITS] == '0));

  p_evict_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr) |-> mem_rd);

  p_fill_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_fin) |=> !mem_rd);
endmodule

bind wbc_cache wbc_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)
) u_chk (.*);

// File: tb/wbc_cache_test.sv
`timescale 1ns/1ps
module wbc_cache_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_stall;
  logic        mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack, mem_fin;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  wbc_cache uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_fin(mem_fin)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [31:0] mem_w  [1024];
  logic [31:0] shadow [1024];
  int          wb_count = 0, fill_count = 0;
  int          last_wb_blk = 0;
  int          bb = 0;

  always @(negedge clk) begin
    mem_ack   = (mem_rd || mem_wr) && ($urandom % 4 != 0);
    mem_fin   = mem_ack && (mem_addr[4:2] == 3'd7);
    mem_rdata = mem_w[mem_addr[11:2]];
    if (mem_rd || mem_wr)
      chk(!(mem_rd && mem_wr), "R9 rd/wr exclusive", {mem_rd, mem_wr}, 0);
  end

  always @(posedge clk) begin
    if ((mem_rd || mem_wr) && mem_ack) begin
      chk(mem_addr[4:2] == bb[2:0], "R4 beat order", mem_addr[4:2], bb);
      if (mem_wr) mem_w[mem_addr[11:2]] = mem_wdata;
      if (mem_fin) begin
        bb = 0;
        if (mem_wr) begin wb_count++; last_wb_blk = int'(mem_addr[31:5]); end
        else fill_count++;
      end else bb++;
    end
  end

  // ---------------- reference model ----------------
  int m_tag [16][4];
  bit m_val [16][4];
  bit m_dty [16][4];
  int m_age [16][4];

  function automatic logic [31:0] mk(input int tg, input int st, input int wd);
    return (32'(tg) << 9) | (32'(st) << 5) | (32'(wd) << 2);
  endfunction

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd, input string what);
    int st, tg, widx, hw, vic, wb0, fl0, n, way, old;
    bit exp_wb;
    int exp_blk;
    st = int'(addr[8:5]); tg = int'(addr[31:9]); widx = int'(addr[11:2]);
    hw = -1; vic = -1;
    for (int w = 0; w < 4; w++) if (m_val[st][w] && m_tag[st][w] == tg) hw = w;
    if (hw < 0) begin
      for (int w = 3; w >= 0; w--) if (!m_val[st][w]) vic = w;
      if (vic < 0) for (int w = 0; w < 4; w++) if (m_age[st][w] == 3) vic = w;
    end
    exp_wb  = (hw < 0) && m_dty[st][vic];
    exp_blk = (hw < 0) ? ((m_tag[st][vic] << 4) | st) : 0;
    wb0 = wb_count; fl0 = fill_count;

    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    #1;
    chk(cpu_stall == (hw < 0), {"R2 hit/miss detect ", what}, cpu_stall, hw < 0);
    n = 0;
    while (cpu_stall && n < 3000) begin @(negedge clk); #1; n++; end
    chk(n < 3000, {"R4 stall released ", what}, n, 0);
    if (!we)
      chk(cpu_rdata == shadow[widx], {"R2 read data (R4 R6 after misses) ", what},
          cpu_rdata, shadow[widx]);
    else
      shadow[widx] = wd;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0;

    if (hw >= 0)
      chk(wb_count == wb0 && fill_count == fl0, {"R3 no memory traffic on hit ", what},
          (wb_count - wb0) + (fill_count - fl0), 0);
    else begin
      chk(fill_count - fl0 == 1, {"R4 one refill ", what}, fill_count - fl0, 1);
      chk(wb_count - wb0 == int'(exp_wb), {"R6 writeback only if dirty (R7 R8 victim) ", what},
          wb_count - wb0, exp_wb);
      if (exp_wb)
        chk(last_wb_blk == exp_blk, {"R6 writeback address (R7 LRU) ", what}, last_wb_blk, exp_blk);
    end

    way = (hw >= 0) ? hw : vic;
    if (hw < 0) begin m_val[st][way] = 1; m_tag[st][way] = tg; m_dty[st][way] = 0; end
    old = m_age[st][way];
    for (int w = 0; w < 4; w++)
      if (w == way) m_age[st][w] = 0;
      else if (m_age[st][w] < old) m_age[st][w]++;
    if (we) m_dty[st][way] = 1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin
      mem_w[i]  = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A_0000;
      shadow[i] = mem_w[i];
    end
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        m_val[s][w] = 0; m_dty[s][w] = 0; m_tag[s][w] = 0; m_age[s][w] = w;
      end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!cpu_stall, "R10 no stall after reset", cpu_stall, 0);
    chk(!mem_rd && !mem_wr, "R10 no memory request after reset", {mem_rd, mem_wr}, 0);

    // R8: four misses fill the empty ways, no writebacks
    access(0, mk(0, 3, 1), 0, "R8 fill tag0");
    access(0, mk(1, 3, 2), 0, "R8 fill tag1");
    access(0, mk(2, 3, 3), 0, "R8 fill tag2");
    access(0, mk(3, 3, 4), 0, "R8 fill tag3");
    // R2 hit, R3 write hit
    access(0, mk(0, 3, 5), 0, "R2 hit tag0");
    access(1, mk(1, 3, 6), 32'hCAFE_0001, "R3 write hit tag1");
    access(0, mk(1, 3, 6), 0, "R3 readback tag1");
    // R1 byte offset ignored
    access(0, mk(1, 3, 6) | 32'h3, 0, "R1 byte bits ignored");
    // R7 LRU order: evict tag2, tag3, tag0 (clean), then tag1 (dirty)
    access(0, mk(4, 3, 0), 0, "R7 evict lru clean");
    access(0, mk(5, 3, 0), 0, "R7 evict next clean");
    access(0, mk(6, 3, 0), 0, "R7 evict third clean");
    access(0, mk(7, 3, 0), 0, "R6 evict dirty tag1");
    access(0, mk(1, 3, 6), 0, "R6 data survived writeback");
    // R5 write miss allocates and dirties
    access(1, mk(2, 5, 7), 32'hBEEF_0005, "R5 write miss");
    access(0, mk(2, 5, 7), 0, "R5 readback hit");
    for (int t = 3; t < 7; t++) access(0, mk(t, 5, 0), 0, "R5 force dirty eviction");
    access(0, mk(2, 5, 7), 0, "R5 refill after writeback");

    // Random mix over four sets and eight tags
    for (int i = 0; i < 400; i++) begin
      bit we;
      we = ($urandom % 3 == 0);
      access(we, mk($urandom % 8, $urandom % 4, $urandom % 8), $urandom, "random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule